// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing heart of a PWM generator. A 16-bit counter steps once per prescaler tick and sweeps between zero and a programmable period, counting up, counting down, or counting up then down. The block publishes the counter value, the current count direction, and one-cycle strobes when a step lands on zero or on the period. Compare and output logic downstream turns these into waveforms.

Configuration arrives through two write-enable ports: a 16-bit control word and a 16-bit period word. The control word selects the count mode, the run behaviour, the two prescaler divider codes, and whether a period write takes effect at once or waits in a shadow register until the counter next arrives at zero. The run field can halt the counter in place, or let it finish the cycle in progress and park at zero, or let it run without end.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the count is 0, both events are low, the direction output is 0 (up), both period registers are 0, and the control word is 0x0003 (frozen), so the count stays at 0 until the control word is written.
- R2: Count mode 00 (control bits [1:0]) counts up by one per step from 0 to the active period, and the step after the count is at or above the period lands on 0.
- R3: Count mode 01 counts down by one per step, and the step after the count is 0 loads the active period; the direction output is 1.
- R4: Count mode 10 counts up until the count reaches the period, then steps down to 0, then up again; the direction output is 0 while rising and 1 after the turn at the top, and returns to 0 after the turn at the bottom.
- R5: Count mode 11 freezes the count; ticks have no effect on it.
- R6: Run field 00 (control bits [15:14]) halts the count at its present value.
- R7: Run field 01 lets the count advance only while it is non-zero, so it finishes the cycle in progress and parks at 0; run fields 10 and 11 run freely.
- R8: A step happens once every D clock cycles, where D = H × 2^K, H = 1 when control bits [9:7] are 0 and 2 × that field otherwise, and K is control bits [12:10].
- R9: With control bit 3 at 0, a period write goes to the shadow register only; the active period takes the shadow value on the edge where a step lands on 0.
- R10: With control bit 3 at 1, a period write updates both the active and the shadow period on that edge.
- R11: zero_evt is high for the one cycle after a step lands on 0, and prd_evt is high for the one cycle after a step lands on the active period; neither is high without a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word: [15:14] run, [12:10] second divider code, [9:7] high-speed divider code, [3] immediate period load, [1:0] count mode |
| prd_wr | input | 1 | Write strobe for the period |
| prd_wdata | input | 16 | Period value |
| tb_count | output | 16 | Counter value |
| tb_dir_down | output | 1 | Count direction, 1 while counting down |
| tb_zero | output | 1 | One-cycle strobe: a step landed on zero |
| tb_period | output | 1 | One-cycle strobe: a step landed on the active period |

## Verification
The bench goes after the odd divider encodings, where a design that doubled the zero code or treated the first stage as a power of two would step at the wrong rate for codes 0, 3 and 7. It writes a shadowed period mid-cycle and checks that the old period still bounds the sweep until the counter reaches zero; a design that loaded at once would overshoot or cut the cycle short. It parks the counter with the finish-cycle run code and checks that it stops exactly at zero rather than halting where it stood, and it watches both turnarounds of up-down mode, where an off-by-one design would repeat the top or bottom value or flip direction a step late. Random control and period writes, including periods of zero and shrinking periods, are compared cycle by cycle against a reference model.

// File: rtl/tbc_pkg.sv
// Shared definitions for the PWM time-base: control word layout and the
// encodings of the count and run fields.
package tbc_pkg;

    localparam int CTRL_W   = 16;
    localparam int MODE_LSB = 0;
    localparam int LOAD_BIT = 3;
    localparam int HS_LSB   = 7;
    localparam int CK_LSB   = 10;
    localparam int RUN_LSB  = 14;
    localparam int SEL_W    = 3;

    typedef enum logic [1:0] {
        CM_UP    = 2'b00,
        CM_DOWN  = 2'b01,
        CM_UPDN  = 2'b10,
        CM_HOLD  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT   = 2'b00,
        RUN_FINISH = 2'b01,
        RUN_FREE_A = 2'b10,
        RUN_FREE_B = 2'b11
    } run_mode_e;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0003;

endpackage

// File: rtl/tbc_prescaler.sv
// Two-stage clock-enable prescaler.
// Produces a one-cycle tick every D cycles with D = H * 2^K, where H is 1 for
// a zero high-speed code and twice the code otherwise, and K is the second
// stage code. Assumes the codes may change at any time; a compare with >=
// keeps a shrinking divider from stretching the current interval.
module tbc_prescaler #(
    parameter int HS_W = 3,
    parameter int CK_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HS_W-1:0] hs_sel,
    input  logic [CK_W-1:0] ck_sel,
    output logic            tick
);
    localparam int HS_DIV_W = HS_W + 1;
    localparam int DIV_W    = HS_DIV_W + (1 << CK_W) - 1;

    logic [HS_DIV_W-1:0] hs_div;
    logic [DIV_W-1:0]    total;
    logic [DIV_W-1:0]    limit;
    logic [DIV_W-1:0]    acc;

    // Decode the two divider codes into the terminal count.
    always_comb begin
        if (hs_sel == '0) begin
            hs_div = HS_DIV_W'(1);
        end else begin
            hs_div = {hs_sel, 1'b0};
        end
        total = DIV_W'(hs_div) << ck_sel;
        limit = total - DIV_W'(1);
        tick  = (acc >= limit);
    end

    // Count clock cycles between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (tick) begin
            acc <= '0;
        end else begin
            acc <= acc + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tbc_period.sv
// Period register pair: a shadow copy that takes every write and the active
// copy that the counter compares against. Assumes reload is a one-cycle pulse
// raised on the edge where a counter step lands on zero.
module tbc_period #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         imm_mode,
    input  logic         reload,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow;

    // Capture writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            shadow <= wr_data;
        end
    end

    // Update the active copy: immediate write first, else zero-crossing reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (wr_en && imm_mode) begin
            active <= wr_data;
        end else if (reload) begin
            active <= shadow;
        end
    end
endmodule

// File: rtl/tbc_counter.sv
// Time-base counter with up, down, up-down and hold modes and three run
// behaviours. Advances only on a prescaler tick. Raises one-cycle strobes
// when a step lands on zero or on the period. Assumes mode, run and period
// are registered upstream.
module tbc_counter
    import tbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  run_mode_e    run,
    input  logic [W-1:0] prd,
    output logic [W-1:0] count,
    output logic         dir_down,
    output logic         zero_evt,
    output logic         prd_evt,
    output logic         step,
    output logic         land_zero
);
    logic [W-1:0] nxt;
    logic         nxt_dir;
    logic         run_ok;

    // Decide whether this tick moves the counter.
    always_comb begin
        run_ok = (run == RUN_FREE_A) || (run == RUN_FREE_B) ||
                 ((run == RUN_FINISH) && (count != '0));
        step   = tick && run_ok && (mode != CM_HOLD);
    end

    // Next count and direction for each mode.
    always_comb begin
        nxt     = count;
        nxt_dir = dir_down;
        unique case (mode)
            CM_UP: begin
                nxt     = (count >= prd) ? '0 : count + W'(1);
                nxt_dir = 1'b0;
            end
            CM_DOWN: begin
                nxt     = (count == '0) ? prd : count - W'(1);
                nxt_dir = 1'b1;
            end
            CM_UPDN: begin
                if (!dir_down) begin
                    if (count < prd) begin
                        nxt     = count + W'(1);
                        nxt_dir = 1'b0;
                    end else begin
                        nxt     = (count == '0) ? '0 : count - W'(1);
                        nxt_dir = 1'b1;
                    end
                end else begin
                    if (count != '0) begin
                        nxt     = count - W'(1);
                        nxt_dir = 1'b1;
                    end else begin
                        nxt     = (prd == '0) ? '0 : W'(1);
                        nxt_dir = 1'b0;
                    end
                end
            end
            default: begin
                nxt     = count;
                nxt_dir = dir_down;
            end
        endcase
        land_zero = step && (nxt == '0);
    end

    // Register the count, direction and event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            dir_down <= 1'b0;
            zero_evt <= 1'b0;
            prd_evt  <= 1'b0;
        end else begin
            zero_evt <= land_zero;
            prd_evt  <= step && (nxt == prd);
            if (step) begin
                count    <= nxt;
                dir_down <= nxt_dir;
            end
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
// PWM time-base top: holds the control word, and ties the prescaler, the
// period registers and the counter together. Assumes writes are single-cycle
// strobes from a bus adapter outside this block.
module pwm_timebase
    import tbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic [15:0]  ctrl_wdata,
    input  logic         prd_wr,
    input  logic [W-1:0] prd_wdata,
    output logic [W-1:0] tb_count,
    output logic         tb_dir_down,
    output logic         tb_zero,
    output logic         tb_period
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [W-1:0]      prd_active;
    logic              ps_tick;
    logic              cnt_step;
    logic              cnt_land_zero;
    cnt_mode_e         mode;
    run_mode_e         run;

    // Hold the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    // Decode the mode fields.
    always_comb begin
        mode = cnt_mode_e'(ctrl_q[MODE_LSB +: 2]);
        run  = run_mode_e'(ctrl_q[RUN_LSB +: 2]);
    end

    tbc_prescaler #(
        .HS_W (SEL_W),
        .CK_W (SEL_W)
    ) i_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_sel (ctrl_q[HS_LSB +: SEL_W]),
        .ck_sel (ctrl_q[CK_LSB +: SEL_W]),
        .tick   (ps_tick)
    );

    tbc_period #(
        .W (W)
    ) i_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (prd_wr),
        .wr_data  (prd_wdata),
        .imm_mode (ctrl_q[LOAD_BIT]),
        .reload   (cnt_land_zero),
        .active   (prd_active)
    );

    tbc_counter #(
        .W (W)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ps_tick),
        .mode      (mode),
        .run       (run),
        .prd       (prd_active),
        .count     (tb_count),
        .dir_down  (tb_dir_down),
        .zero_evt  (tb_zero),
        .prd_evt   (tb_period),
        .step      (cnt_step),
        .land_zero (cnt_land_zero)
    );
endmodule

// File: rtl/tbc_checker.sv
// Property checker for the PWM time-base, attached to every instance of the
// top module by the bind below.
module tbc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctrl_wr,
    input logic [15:0]  ctrl_wdata,
    input logic [15:0]  ctrl_q,
    input logic         prd_wr,
    input logic [W-1:0] prd_wdata,
    input logic [W-1:0] prd_act,
    input logic [W-1:0] count,
    input logic         step,
    input logic         zero_evt
);
    p_ctrl_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q == $past(ctrl_wdata)));

    p_ctrl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[1:0] == 2'b00) && step && (count < prd_act))
        |=> (count == $past(count) + W'(1)));

    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[1:0] == 2'b01) && step && (count != '0))
        |=> (count == $past(count) - W'(1)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b11) |=> $stable(count));

    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[15:14] == 2'b00) |=> $stable(count));

    p_imm_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_wr && ctrl_q[3]) |=> (prd_act == $past(prd_wdata)));

    p_zero_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (count == '0));
endmodule

bind pwm_timebase tbc_checker #(.W(W)) i_tbc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_q     (ctrl_q),
    .prd_wr     (prd_wr),
    .prd_wdata  (prd_wdata),
    .prd_act    (prd_active),
    .count      (tb_count),
    .step       (cnt_step),
    .zero_evt   (tb_zero)
);

// File: tb/test_pwm_timebase.sv
// Bench for the PWM time-base: directed corner cases plus seeded random
// writes, compared every cycle against a reference model built from the
// requirements.
module test_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic [15:0] tb_count;
    logic        tb_dir_down;
    logic        tb_zero;
    logic        tb_period;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwm_timebase i_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata), .tb_count(tb_count),
        .tb_dir_down(tb_dir_down), .tb_zero(tb_zero), .tb_period(tb_period)
    );

    // Reference model state
    logic [15:0] m_ctrl = 16'h0003;
    int m_acc = 0, m_cnt = 0, m_sh = 0, m_act = 0;
    bit m_dir = 0, m_ze = 0, m_pe = 0;
    int t_lim, t_nxt, t_old_sh;
    bit t_tick, t_go, t_nd, t_ze, t_pe;

    function automatic int divide_of(logic [15:0] c);
        int h;
        h = (c[9:7] == 0) ? 1 : 2 * int'(c[9:7]);
        return h * (1 << c[12:10]);
    endfunction

    function automatic logic [15:0] mk(int run, int ck, int hs, int imm, int mode);
        return {2'(run), 1'b0, 3'(ck), 3'(hs), 3'b000, 1'(imm), 1'b0, 2'(mode)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 16'h0003; m_acc = 0; m_cnt = 0; m_dir = 0;
            m_sh = 0; m_act = 0; m_ze = 0; m_pe = 0;
        end else begin
            t_lim  = divide_of(m_ctrl) - 1;
            t_tick = (m_acc >= t_lim);
            m_acc  = t_tick ? 0 : m_acc + 1;
            t_go   = t_tick && m_ctrl[1:0] != 2'b11 &&
                     (m_ctrl[15] || (m_ctrl[15:14] == 2'b01 && m_cnt != 0));
            t_nxt = m_cnt; t_nd = m_dir;
            case (m_ctrl[1:0])
                2'b00: begin t_nd = 0; t_nxt = (m_cnt >= m_act) ? 0 : m_cnt + 1; end
                2'b01: begin t_nd = 1; t_nxt = (m_cnt == 0) ? m_act : m_cnt - 1; end
                2'b10: begin
                    if (!m_dir && m_cnt < m_act) begin t_nd = 0; t_nxt = m_cnt + 1; end
                    else if (!m_dir) begin t_nd = 1; t_nxt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else if (m_cnt > 0) begin t_nd = 1; t_nxt = m_cnt - 1; end
                    else begin t_nd = 0; t_nxt = (m_act == 0) ? 0 : 1; end
                end
                default: ;
            endcase
            t_ze = t_go && (t_nxt == 0);
            t_pe = t_go && (t_nxt == m_act);
            t_old_sh = m_sh;
            if (prd_wr) m_sh = int'(prd_wdata);
            if (prd_wr && m_ctrl[3]) m_act = int'(prd_wdata);
            else if (t_ze) m_act = t_old_sh;
            if (t_go) begin m_cnt = t_nxt; m_dir = t_nd; end
            m_ze = t_ze; m_pe = t_pe;
            if (ctrl_wr) m_ctrl = ctrl_wdata;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        string tag;
        case (m_ctrl[1:0])
            2'b00: tag = "R2 count";
            2'b01: tag = "R3 count";
            2'b10: tag = "R4 count";
            default: tag = "R5 count";
        endcase
        check(tag, int'(tb_count), m_cnt);
        check("R4 direction", int'(tb_dir_down), int'(m_dir));
        check("R11 zero_evt", int'(tb_zero), int'(m_ze));
        check("R11 prd_evt", int'(tb_period), int'(m_pe));
    endtask

    task automatic cyc();
        @(negedge clk);
        cmp_model();
        ctrl_wr = 1'b0;
        prd_wr  = 1'b0;
    endtask

    task automatic put_ctrl(logic [15:0] v);
        cyc();
        ctrl_wr = 1'b1; ctrl_wdata = v;
    endtask

    task automatic put_prd(int v);
        cyc();
        prd_wr = 1'b1; prd_wdata = 16'(v);
    endtask

    task automatic wait_count(int v);
        for (int i = 0; i < 200; i++) begin
            if (int'(tb_count) == v) break;
            cyc();
        end
    endtask

    // Cycles between two successive counter changes.
    task automatic step_gap(string tag, int exp);
        int last, gap;
        cyc();
        last = int'(tb_count);
        for (int i = 0; i < 100; i++) begin
            cyc();
            if (int'(tb_count) != last) break;
        end
        last = int'(tb_count);
        gap = 0;
        for (int i = 0; i < 100; i++) begin
            cyc();
            gap++;
            if (int'(tb_count) != last) break;
        end
        check(tag, gap, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int mx, mx_before, v, seed;
        bit seen_zero;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        // R1: reset state and frozen after reset
        for (int i = 0; i < 3; i++) cyc();
        rst_n = 1'b1;
        cyc();
        check("R1 count", int'(tb_count), 0);
        check("R1 zero_evt", int'(tb_zero), 0);
        check("R1 prd_evt", int'(tb_period), 0);
        check("R1 dir", int'(tb_dir_down), 0);
        for (int i = 0; i < 6; i++) cyc();
        check("R1 frozen count", int'(tb_count), 0);

        // R2 and R10: immediate period 5, up mode, divide 1
        put_ctrl(mk(3, 0, 0, 1, 3));
        put_prd(5);
        put_ctrl(mk(3, 0, 0, 1, 0));
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            cyc();
            if (int'(tb_count) > mx) mx = int'(tb_count);
        end
        check("R2 up-mode max equals period", mx, 5);
        put_prd(16'hFFFF);
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            cyc();
            if (int'(tb_count) > mx) mx = int'(tb_count);
        end
        check("R10 immediate load lifts bound", int'(mx > 5), 1);

        // R9: shadowed period waits for zero
        put_prd(5);
        for (int i = 0; i < 8; i++) cyc();
        put_ctrl(mk(3, 0, 0, 0, 0));
        wait_count(2);
        put_prd(9);
        mx = 0; mx_before = 0; seen_zero = 0;
        for (int i = 0; i < 40; i++) begin
            cyc();
            if (int'(tb_count) == 0) seen_zero = 1;
            if (!seen_zero && int'(tb_count) > mx_before) mx_before = int'(tb_count);
            if (int'(tb_count) > mx) mx = int'(tb_count);
        end
        check("R9 old period bounds until zero", mx_before, 5);
        check("R9 new period after zero", mx, 9);

        // R8: prescaler encodings
        put_ctrl(mk(3, 1, 3, 0, 0));
        step_gap("R8 divide hs3 ck1", 12);
        put_ctrl(mk(3, 2, 0, 0, 0));
        step_gap("R8 divide hs0 ck2", 4);
        put_ctrl(mk(3, 0, 7, 0, 0));
        step_gap("R8 divide hs7 ck0", 14);
        put_ctrl(mk(3, 0, 0, 0, 0));
        step_gap("R8 divide hs0 ck0", 1);

        // R3: down mode
        put_ctrl(mk(3, 0, 0, 0, 1));
        wait_count(9);
        cyc();
        check("R3 down step", int'(tb_count), 8);
        check("R3 direction down", int'(tb_dir_down), 1);
        wait_count(0);
        cyc();
        check("R3 reload period after zero", int'(tb_count), 9);

        // R4 and R11: up-down turnarounds
        put_ctrl(mk(3, 0, 0, 0, 2));
        wait_count(0);
        wait_count(9);
        check("R11 prd_evt at top", int'(tb_period), 1);
        cyc();
        check("R4 turn at top", int'(tb_count), 8);
        check("R4 direction after top", int'(tb_dir_down), 1);
        wait_count(0);
        check("R11 zero_evt at bottom", int'(tb_zero), 1);
        cyc();
        check("R4 turn at bottom", int'(tb_count), 1);
        check("R4 direction after bottom", int'(tb_dir_down), 0);

        // R5: freeze
        put_ctrl(mk(3, 0, 0, 0, 3));
        cyc();
        v = int'(tb_count);
        for (int i = 0; i < 10; i++) cyc();
        check("R5 frozen count", int'(tb_count), v);
        check("R11 no event when frozen", int'(tb_zero | tb_period), 0);

        // R6: halt in place
        put_ctrl(mk(3, 0, 0, 0, 0));
        wait_count(4);
        put_ctrl(mk(0, 0, 0, 0, 0));
        cyc();
        v = int'(tb_count);
        for (int i = 0; i < 10; i++) cyc();
        check("R6 halted count", int'(tb_count), v);
        check("R6 halted away from zero", int'(v != 0), 1);

        // R7: finish cycle and park at zero
        put_ctrl(mk(3, 0, 0, 0, 0));
        wait_count(3);
        put_ctrl(mk(1, 0, 0, 0, 0));
        for (int i = 0; i < 20; i++) cyc();
        check("R7 parked at zero", int'(tb_count), 0);
        for (int i = 0; i < 10; i++) cyc();
        check("R7 stays parked", int'(tb_count), 0);

        // Seeded random configuration and period writes
        for (int i = 0; i < 4000; i++) begin
            cyc();
            if ($urandom_range(19) == 0) begin
                ctrl_wr = 1'b1;
                ctrl_wdata = mk($urandom_range(3), $urandom_range(1),
                                $urandom_range(2), $urandom_range(1),
                                $urandom_range(3));
            end
            if ($urandom_range(14) == 0) begin
                prd_wr = 1'b1;
                prd_wdata = 16'($urandom_range(12));
            end
        end
        cyc();

        summary();
        $finish;
    end
endmodule